// File: doc/BRIEF.md
# UART FIFO Control with Trigger Thresholds

This block holds the FIFO control word of a UART-style peripheral and the two byte queues that word governs: one for received characters and one for characters waiting to be sent. The host writes an 8-bit control word. Through that word it switches both queues between a deep buffered mode and a single-byte holding mode, and it picks a DMA signalling mode that is passed on as an output. It also picks a threshold for each queue from a fixed four-entry menu, and it can order either queue to be emptied. The register cannot be read back. The block reports its state only through the per-queue threshold flags, the full and empty flags, the occupancy counts and the error pulses.

The receive threshold counts stored characters. The transmit threshold counts free slots. The two menus are different and neither is linear. Changing the transmit threshold counts as an enhanced function, so a write only changes it while the external enhanced-mode enable is high. A flush command clears itself: it empties its queue in the cycle after the write and then drops back to idle without further action from the host. The serial shifters, the baud timing and the DMA handshake waveforms sit outside this block and are untouched by a flush.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are in holding mode (`fifo_en`=0), `dma_mode`=0, both threshold selections are code 00, no flush is pending, and both queues are empty with count 0.
- R2: Control bits 7:6 choose the receive threshold in characters: code 00 gives 8, 01 gives 16, 10 gives 56, 11 gives 60. In buffered mode `rx_trig` is 1 exactly when `rx_count` is at least that threshold.
- R3: Control bits 5:4 choose the transmit threshold in free slots: code 00 gives 8, 01 gives 16, 10 gives 32, 11 gives 56. In buffered mode `tx_trig` is 1 exactly when 64 minus `tx_count` is at least that threshold.
- R4: A write changes bits 5:4 only while `enh_en` is 1. When `enh_en` is 0, the transmit threshold keeps its previous value, and the other fields of the same write still take effect.
- R5: Control bit 3 is stored and driven on `dma_mode`.
- R6: Writing 1 to control bit 2 empties the transmit queue one cycle after the write and leaves the receive queue unchanged. The command clears itself and does not repeat on later cycles.
- R7: Writing 1 to control bit 1 empties the receive queue one cycle after the write and leaves the transmit queue unchanged. The command clears itself and does not repeat on later cycles.
- R8: Control bit 0 selects buffered mode, where each queue holds 64 bytes and is full at 64. When bit 0 is 0, each queue holds a single byte and is full at 1. In that mode `rx_trig` follows occupancy (count at least 1) and `tx_trig` is 1 only while the queue is empty.
- R9: Each queue returns bytes in the order they were pushed. The head byte is visible on its data output before it is popped.
- R10: A push to a full queue is dropped and raises the queue's overflow output for one cycle. A pop from an empty queue is dropped and raises the underflow output for one cycle.
- R11: In the cycle a flush takes effect, any push or pop on that queue is discarded and raises no overflow or underflow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| enh_en | input | 1 | Enhanced-function enable; gates transmit threshold updates |
| rx_push | input | 1 | Store a received byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the head receive byte |
| rx_dout | output | 8 | Head receive byte |
| rx_count | output | 7 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_trig | output | 1 | Receive threshold reached |
| rx_ovf | output | 1 | Receive overflow pulse |
| rx_unf | output | 1 | Receive underflow pulse |
| tx_push | input | 1 | Store a byte to send |
| tx_din | input | 8 | Byte to send |
| tx_pop | input | 1 | Remove the head transmit byte |
| tx_dout | output | 8 | Head transmit byte |
| tx_count | output | 7 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_trig | output | 1 | Transmit free-space threshold reached |
| tx_ovf | output | 1 | Transmit overflow pulse |
| tx_unf | output | 1 | Transmit underflow pulse |
| fifo_en | output | 1 | Buffered mode active |
| dma_mode | output | 1 | Selected DMA signalling mode |

## Verification
The bench walks every receive and transmit threshold code across all occupancies from empty to full. A design that swapped menu entries, counted characters instead of free slots on the transmit side, or used a strict comparison would fail at the exact boundary count. It writes a new transmit code while `enh_en` is low and shows that the old threshold still decides `tx_trig`, which exposes a design that lets the gated field through. It pushes and pops during the flush cycle, and also checks that a flush of one queue leaves the other alone and does not clear later pushes. Those cases catch a flush that is slow, sticky or aimed at the wrong queue. Holding mode is checked for a capacity of one and for threshold flags that follow occupancy, and pushes to a full queue and pops from an empty one must produce single-cycle pulses.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;

  // Control word field positions; the host encodes against these.
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned RXSEL_HI   = 7;
  localparam int unsigned RXSEL_LO   = 6;
  localparam int unsigned TXSEL_HI   = 5;
  localparam int unsigned TXSEL_LO   = 4;
  localparam int unsigned DMA_BIT    = 3;
  localparam int unsigned TXFLSH_BIT = 2;
  localparam int unsigned RXFLSH_BIT = 1;
  localparam int unsigned EN_BIT     = 0;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma;
    logic       en;
  } fctl_t;

  // Receive threshold menu, in stored characters.
  function automatic int unsigned rx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // Transmit threshold menu, in free slots.
  function automatic int unsigned tx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/ufc_rst_sync.sv
module ufc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
  import uart_fifo_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             enh_en,
  output fctl_t            ctl,
  output logic             rx_flush,
  output logic             tx_flush
);

  fctl_t ctl_q, ctl_d;
  logic  rxf_q, rxf_d;
  logic  txf_q, txf_d;

  always_comb begin
    ctl_d = ctl_q;
    rxf_d = 1'b0;
    txf_d = 1'b0;
    if (we) begin
      ctl_d.rx_sel = wdata[RXSEL_HI:RXSEL_LO];
      ctl_d.dma    = wdata[DMA_BIT];
      ctl_d.en     = wdata[EN_BIT];
      if (enh_en) ctl_d.tx_sel = wdata[TXSEL_HI:TXSEL_LO];
      rxf_d = wdata[RXFLSH_BIT];
      txf_d = wdata[TXFLSH_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rxf_q <= 1'b0;
      txf_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      rxf_q <= rxf_d;
      txf_q <= txf_d;
    end
  end

  assign ctl      = ctl_q;
  assign rx_flush = rxf_q;
  assign tx_flush = txf_q;

  // R4: gated field holds while enhanced mode is off
  assert_txsel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !enh_en) |=> (ctl_q.tx_sel == $past(ctl_q.tx_sel)));

  // R6: transmit flush command clears itself
  assert_txflush_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_q && !we) |=> !txf_q);

  // R7: receive flush command clears itself
  assert_rxflush_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_q && !we) |=> !rxf_q);

endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 64,
  parameter bit          IS_TX  = 1'b0,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic [CW-1:0] level,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          trig,
  output logic          ovf,
  output logic          unf
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic [CW-1:0] cap;
  logic [CW-1:0] thr;
  logic          push_ok, pop_ok;

  always_comb begin
    cap = en ? CW'(DEPTH) : CW'(1);
    thr = en ? level : CW'(1);
  end

  assign full  = (cnt_q >= cap);
  assign empty = (cnt_q == '0);

  always_comb begin
    push_ok = push && !full  && !flush;
    pop_ok  = pop  && !empty && !flush;
    ovf_d   = push && full   && !flush;
    unf_d   = pop  && empty  && !flush;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + AW'(1);
      if (pop_ok)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Storage carries no reset; only written slots are ever read.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign unf   = unf_q;

  generate
    if (IS_TX) begin : g_space
      logic [CW-1:0] space;
      always_comb begin
        space = (cnt_q >= cap) ? '0 : (cap - cnt_q);
        trig  = (space >= thr);
      end
    end else begin : g_fill
      always_comb begin
        trig = (cnt_q >= thr);
      end
    end
  endgenerate

  // R8: occupancy never exceeds the deep capacity
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R10: a push into a full queue leaves a pulse and no growth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (ovf && $stable(cnt_q)));

  // R10: a pop from an empty queue leaves a pulse
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush) |=> unf);

  // R11: a flush empties the queue and suppresses error pulses
  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !ovf && !unf));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_ctl_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          enh_en,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [CW-1:0] rx_count,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          rx_trig,
  output logic          rx_ovf,
  output logic          rx_unf,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [CW-1:0] tx_count,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          tx_trig,
  output logic          tx_ovf,
  output logic          tx_unf,
  output logic          fifo_en,
  output logic          dma_mode
);

  logic          rst_n_s;
  fctl_t         ctl;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] rx_thr, tx_thr;

  ufc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ufc_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .enh_en   (enh_en),
    .ctl      (ctl),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  always_comb begin
    rx_thr = CW'(rx_level(ctl.rx_sel));
    tx_thr = CW'(tx_level(ctl.tx_sel));
  end

  ufc_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b0)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (ctl.en),
    .flush (rx_flush),
    .level (rx_thr),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .dout  (rx_dout),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty),
    .trig  (rx_trig),
    .ovf   (rx_ovf),
    .unf   (rx_unf)
  );

  ufc_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b1)) u_txq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (ctl.en),
    .flush (tx_flush),
    .level (tx_thr),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty),
    .trig  (tx_trig),
    .ovf   (tx_ovf),
    .unf   (tx_unf)
  );

  assign fifo_en  = ctl.en;
  assign dma_mode = ctl.dma;

  // R5: mode output tracks the written bit one cycle later
  assert_dma_follows_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl_we |=> (dma_mode == $past(ctl_wdata[3])));

endmodule

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic       enh_en;
  logic       rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] rx_din, tx_din;
  logic [7:0] rx_dout, tx_dout;
  logic [6:0] rx_count, tx_count;
  logic       rx_full, rx_empty, rx_trig, rx_ovf, rx_unf;
  logic       tx_full, tx_empty, tx_trig, tx_ovf, tx_unf;
  logic       fifo_en, dma_mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .enh_en(enh_en),
    .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty), .rx_trig(rx_trig),
    .rx_ovf(rx_ovf), .rx_unf(rx_unf),
    .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .tx_trig(tx_trig),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .fifo_en(fifo_en), .dma_mode(dma_mode)
  );

  function automatic int rxl(input int c);
    return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
  endfunction

  function automatic int txl(input int c);
    return (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 32 : 56;
  endfunction

  function automatic logic [7:0] pat(input int i, input int c);
    return 8'((i * 37 + c * 11 + 5) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ctl_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  // write the control word, then let the flush cycle pass
  task automatic wr(input logic [7:0] w);
    ctl_we = 1; ctl_wdata = w;
    step();
    ctl_we = 0;
    step();
  endtask

  task automatic rpush(input logic [7:0] d);
    rx_push = 1; rx_din = d; step(); rx_push = 0;
  endtask

  task automatic rpop();
    rx_pop = 1; step(); rx_pop = 0;
  endtask

  task automatic tpush(input logic [7:0] d);
    tx_push = 1; tx_din = d; step(); tx_push = 0;
  endtask

  task automatic tpop();
    tx_pop = 1; step(); tx_pop = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; enh_en = 0; ctl_wdata = 0; rx_din = 0; tx_din = 0;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 fifo_en", int'(fifo_en), 0);
    chk("R1 dma_mode", int'(dma_mode), 0);
    chk("R1 rx_count", int'(rx_count), 0);
    chk("R1 tx_count", int'(tx_count), 0);
    chk("R1 rx_empty", int'(rx_empty), 1);
    chk("R1 tx_empty", int'(tx_empty), 1);
    chk("R1 rx_trig", int'(rx_trig), 0);
    chk("R1 tx_trig", int'(tx_trig), 1);

    // R2, R8, R9, R10: every receive code over full occupancy range
    for (int c = 0; c < 4; c++) begin
      wr({2'(c), 2'b00, 1'b0, 1'b0, 1'b1, 1'b1});
      chk("R8 fifo_en", int'(fifo_en), 1);
      chk("R7 rx_count after flush", int'(rx_count), 0);
      for (int i = 1; i <= 64; i++) begin
        rpush(pat(i, c));
        chk("R2 rx_count", int'(rx_count), i);
        chk("R2 rx_trig", int'(rx_trig), (i >= rxl(c)) ? 1 : 0);
        chk("R8 rx_full", int'(rx_full), (i == 64) ? 1 : 0);
      end
      rpush(8'hEE);
      chk("R10 rx_ovf", int'(rx_ovf), 1);
      chk("R10 rx_count held", int'(rx_count), 64);
      step();
      chk("R10 rx_ovf one cycle", int'(rx_ovf), 0);
      for (int i = 1; i <= 64; i++) begin
        chk("R9 rx_dout", int'(rx_dout), int'(pat(i, c)));
        rpop();
      end
      chk("R9 rx_empty", int'(rx_empty), 1);
      rpop();
      chk("R10 rx_unf", int'(rx_unf), 1);
      step();
      chk("R10 rx_unf one cycle", int'(rx_unf), 0);
    end

    // R3: every transmit code, free-space threshold
    enh_en = 1;
    for (int c = 0; c < 4; c++) begin
      wr({2'b00, 2'(c), 1'b0, 1'b1, 1'b0, 1'b1});
      chk("R6 tx_count after flush", int'(tx_count), 0);
      chk("R3 tx_trig empty", int'(tx_trig), 1);
      for (int i = 1; i <= 64; i++) begin
        tpush(pat(i, c + 4));
        chk("R3 tx_count", int'(tx_count), i);
        chk("R3 tx_trig", int'(tx_trig), ((64 - i) >= txl(c)) ? 1 : 0);
      end
      tpop();
      chk("R9 tx pop count", int'(tx_count), 63);
      chk("R9 tx_dout", int'(tx_dout), int'(pat(2, c + 4)));
    end

    // R4: gated transmit threshold update
    wr(8'b00_01_0_1_0_1);               // enhanced on: level 16, flush tx
    enh_en = 0;
    wr(8'b00_11_0_1_0_1);               // code 3 ignored; flush still works
    chk("R4 tx flush with enh off", int'(tx_count), 0);
    for (int i = 1; i <= 48; i++) tpush(pat(i, 9));
    chk("R4 tx_trig old level kept", int'(tx_trig), 1);
    tpush(8'h11);
    chk("R4 tx_trig below old level", int'(tx_trig), 0);
    enh_en = 1;
    wr(8'b00_11_0_1_0_1);               // now level 56
    for (int i = 1; i <= 8; i++) tpush(pat(i, 3));
    chk("R4 tx_trig new level", int'(tx_trig), 1);
    tpush(8'h22);
    chk("R4 tx_trig new level edge", int'(tx_trig), 0);

    // R5: DMA mode bit
    wr(8'b00_11_1_0_0_1);
    chk("R5 dma_mode set", int'(dma_mode), 1);
    wr(8'b00_11_0_0_0_1);
    chk("R5 dma_mode clear", int'(dma_mode), 0);

    // R6, R7, R11: selective, self-clearing flush with collisions
    wr(8'b00_11_0_1_1_1);
    for (int i = 0; i < 5; i++) rpush(pat(i, 1));
    for (int i = 0; i < 3; i++) tpush(pat(i, 2));
    ctl_we = 1; ctl_wdata = 8'b00_11_0_0_1_1;   // receive flush only
    step();
    ctl_we = 0;
    rx_push = 1; rx_din = 8'h5A; rx_pop = 1;    // collide with flush cycle
    step();
    idle();
    chk("R11 rx_count after collide", int'(rx_count), 0);
    chk("R11 rx_ovf quiet", int'(rx_ovf), 0);
    chk("R11 rx_unf quiet", int'(rx_unf), 0);
    chk("R7 tx untouched", int'(tx_count), 3);
    rpush(8'hA1);
    step();
    rpush(8'hA2);
    chk("R7 flush self-clears", int'(rx_count), 2);
    chk("R9 rx head after flush", int'(rx_dout), 8'hA1);
    ctl_we = 1; ctl_wdata = 8'b00_11_0_1_0_1;   // transmit flush only
    step();
    ctl_we = 0;
    tx_push = 1; tx_din = 8'h77; tx_pop = 1;
    step();
    idle();
    chk("R11 tx_count after collide", int'(tx_count), 0);
    chk("R6 rx untouched", int'(rx_count), 2);
    tpush(8'hB1);
    step();
    chk("R6 flush self-clears", int'(tx_count), 1);

    // R8: holding mode, single entry
    wr(8'b00_11_0_1_1_0);
    chk("R8 fifo_en off", int'(fifo_en), 0);
    chk("R8 hold rx empty trig", int'(rx_trig), 0);
    chk("R8 hold tx empty trig", int'(tx_trig), 1);
    rpush(8'hC3);
    tpush(8'hD4);
    chk("R8 hold rx_full", int'(rx_full), 1);
    chk("R8 hold rx_trig", int'(rx_trig), 1);
    chk("R8 hold tx_full", int'(tx_full), 1);
    chk("R8 hold tx_trig", int'(tx_trig), 0);
    rpush(8'hC4);
    chk("R10 hold rx_ovf", int'(rx_ovf), 1);
    chk("R8 hold rx_count", int'(rx_count), 1);
    chk("R9 hold rx_dout", int'(rx_dout), 8'hC3);
    rpop();
    chk("R8 hold rx drained", int'(rx_empty), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule